// File: doc/BRIEF.md
# External Bus Strobe Timing Generator

This block times the two control strobes of an 8-bit microcontroller-style external memory bus: an active-high address-latch strobe and an active-low program-read strobe. It runs from the oscillator-rate clock. A machine cycle is 12 oscillator periods, six states of two phases each, and a free-running tick counter steps through it. The flags that describe the current machine cycle are sampled once per cycle. The flags are an external data access, execution from external program memory, a data-move or code-move instruction, and a control bit that turns the latch strobe off. The tick index is also an output, so neighbouring logic can line up with the cycle.

The latch strobe pulses twice per machine cycle, one period wide each time, which is one sixth of the oscillator rate. In a machine cycle that touches external data memory, the second of those pulses is dropped and the read strobe stays idle for the whole cycle. When the off bit is set, the latch output rests high except in move-instruction cycles. External execution overrides the off bit. A reset request only takes effect after the reset input has stayed high for two full machine cycles.

Top module: `xbus_strobe_gen`

## Requirements
- R1: `cyc_tick` counts 0,1,...,11 and wraps from 11 to 0, one step per clock. A machine cycle is therefore 12 clocks.
- R2: With normal flags, `lat_stb` is high for exactly one clock at tick 0 and at tick 6 and low at all other ticks. Outside an active reset, `lat_stb` is never low at tick 0.
- R3: In a machine cycle flagged as an external data access, the tick-6 latch pulse is omitted and the tick-0 pulse is kept.
- R4: When the off bit is set, and the cycle is neither external execution nor a move instruction, `lat_stb` stays high for all 12 ticks of the cycle.
- R5: When the off bit is set in a move-instruction cycle, `lat_stb` pulses as in R2, with the omission of R3 if the cycle is also an external data access.
- R6: In an external-execution cycle the off bit has no effect on `lat_stb`.
- R7: In an external-execution cycle without an external data access, `rd_stb_n` is low at ticks 2, 3, 4 and 8, 9, 10 and high at every other tick. In all other cycles it is high throughout.
- R8: In a cycle flagged as an external data access, `rd_stb_n` stays high at all 12 ticks, even with external execution set.
- R9: The four flag inputs are sampled only at the clock edge that ends tick 11, and they apply to the whole of the following machine cycle. Changes at any other time have no effect on the cycle in progress.
- R10: Once `rst` has been high for 24 consecutive clocks, and for as long as it stays high after that, `cyc_tick` is 0, `lat_stb` is 0 and `rd_stb_n` is 1. The first machine cycle after release starts at tick 0 with all flags cleared.
- R11: A high on `rst` that lasts fewer than 24 consecutive clocks has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst | input | 1 | Reset request, qualified by a two-machine-cycle hold |
| xdata_cyc | input | 1 | Current machine cycle accesses external data memory |
| xcode_exec | input | 1 | Code is executing from external program memory |
| mov_insn | input | 1 | Cycle belongs to a data-move or code-move instruction |
| lat_off | input | 1 | Control bit that turns the latch strobe off |
| lat_stb | output | 1 | Address-latch strobe, active high |
| rd_stb_n | output | 1 | Program-read strobe, active low |
| cyc_tick | output | 4 | Position within the machine cycle, 0 to 11 (state*2 + phase) |

## Verification
Two effects can fall in the same machine cycle. The external-data flag drops a latch pulse and silences the read strobe, while the off bit either holds the latch output high or is overridden by external execution or a move instruction. The bench provokes this by driving cycles that combine the external-data flag with the off bit together with a move instruction, and with the off bit together with external execution. Each tick of the cycle is judged against a model that applies the override first and then the pulse omission. The bench also drives the flags to misleading values mid-cycle, which exercises the once-per-cycle sampling alongside those combinations.

// File: rtl/xbus_strobe_gen.sv
module xbus_strobe_gen #(
  parameter int TICKS      = 12,
  parameter int RST_CYCLES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     xdata_cyc,
  input  logic                     xcode_exec,
  input  logic                     mov_insn,
  input  logic                     lat_off,
  output logic                     lat_stb,
  output logic                     rd_stb_n,
  output logic [$clog2(TICKS)-1:0] cyc_tick
);
  localparam int TW   = $clog2(TICKS);
  localparam int HOLD = TICKS * RST_CYCLES;
  localparam int HW   = $clog2(HOLD + 1);
  localparam logic [TW-1:0] LAST  = TW'(TICKS - 1);
  localparam logic [TW-1:0] HALF  = TW'(TICKS / 2);
  localparam logic [TW-1:0] W0_LO = TW'(2);
  localparam logic [TW-1:0] W0_HI = TW'(TICKS / 2 - 2);
  localparam logic [TW-1:0] W1_LO = TW'(TICKS / 2 + 2);
  localparam logic [TW-1:0] W1_HI = TW'(TICKS - 2);

  logic [HW-1:0] hold_q;
  logic          rst_act;
  logic          c_xdata, c_exec, c_mov, c_off;
  logic          lat_gate, lat_slot, fetch_win;

  assign rst_act = (hold_q == HW'(HOLD));

  always_ff @(posedge clk) begin
    if (!rst)         hold_q <= '0;
    else if (!rst_act) hold_q <= hold_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst_act || cyc_tick == LAST) cyc_tick <= '0;
    else                             cyc_tick <= cyc_tick + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst_act) begin
      c_xdata <= 1'b0;
      c_exec  <= 1'b0;
      c_mov   <= 1'b0;
      c_off   <= 1'b0;
    end else if (cyc_tick == LAST) begin
      c_xdata <= xdata_cyc;
      c_exec  <= xcode_exec;
      c_mov   <= mov_insn;
      c_off   <= lat_off;
    end
  end

  assign lat_gate  = !c_off || c_exec || c_mov;
  assign lat_slot  = (cyc_tick == '0) || (cyc_tick == HALF && !c_xdata);
  assign fetch_win = (cyc_tick >= W0_LO && cyc_tick <= W0_HI) ||
                     (cyc_tick >= W1_LO && cyc_tick <= W1_HI);

  assign lat_stb  = !rst_act && (lat_gate ? lat_slot : 1'b1);
  assign rd_stb_n = rst_act || !(c_exec && !c_xdata && fetch_win);
endmodule

// File: rtl/xbus_strobe_chk.sv
module xbus_strobe_chk #(
  parameter int TICKS = 12
) (
  input logic                     clk,
  input logic                     rst_act,
  input logic                     lat_stb,
  input logic                     rd_stb_n,
  input logic [$clog2(TICKS)-1:0] cyc_tick
);
  localparam int TW = $clog2(TICKS);
  localparam logic [TW-1:0] LAST = TW'(TICKS - 1);
  localparam logic [TW-1:0] HALF = TW'(TICKS / 2);

  assert_tick_wrap_R1: assert property (@(posedge clk) disable iff (rst_act)
    (cyc_tick == LAST) |=> (cyc_tick == '0));

  assert_tick_step_R1: assert property (@(posedge clk) disable iff (rst_act)
    (cyc_tick != LAST) |=> (cyc_tick == $past(cyc_tick) + 1'b1));

  assert_first_pulse_kept_R2: assert property (@(posedge clk) disable iff (rst_act)
    (cyc_tick == '0) |-> lat_stb);

  assert_held_high_stays_R4: assert property (@(posedge clk) disable iff (rst_act)
    (lat_stb && cyc_tick == 1) |=> lat_stb);

  assert_read_window_R7: assert property (@(posedge clk) disable iff (rst_act)
    !rd_stb_n |-> ((cyc_tick >= 2 && cyc_tick < HALF - 1) ||
                   (cyc_tick >= HALF + 2 && cyc_tick < LAST)));

  assert_read_pair_R7: assert property (@(posedge clk) disable iff (rst_act)
    (!rd_stb_n && cyc_tick == 2) |=> !rd_stb_n);

  assert_reset_outputs_R10: assert property (@(posedge clk)
    rst_act |-> (!lat_stb && rd_stb_n));
endmodule

bind xbus_strobe_gen xbus_strobe_chk #(.TICKS(TICKS)) u_chk (
  .clk(clk), .rst_act(rst_act), .lat_stb(lat_stb),
  .rd_stb_n(rd_stb_n), .cyc_tick(cyc_tick)
);

// File: tb/test_xbus_strobe_gen.sv
module test_xbus_strobe_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic xdata_cyc = 1'b0, xcode_exec = 1'b0, mov_insn = 1'b0, lat_off = 1'b0;
  logic lat_stb, rd_stb_n;
  logic [3:0] cyc_tick;

  int checks = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic       a;
    logic       p;
    logic [3:0] t;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  xbus_strobe_gen i_xbus_strobe_gen (
    .clk(clk), .rst(rst), .xdata_cyc(xdata_cyc), .xcode_exec(xcode_exec),
    .mov_insn(mov_insn), .lat_off(lat_off), .lat_stb(lat_stb),
    .rd_stb_n(rd_stb_n), .cyc_tick(cyc_tick)
  );

  task automatic push_cycle(input logic ed, input logic ex, input logic mv,
                            input logic ds, input string tag);
    for (int t = 0; t < 12; t++) begin
      exp_t e;
      logic slot, gate;
      slot  = (t == 0) || (t == 6 && !ed);
      gate  = !ds || ex || mv;
      e.a   = gate ? slot : 1'b1;
      e.p   = !(ex && !ed && ((t >= 2 && t <= 4) || (t >= 8 && t <= 10)));
      e.t   = 4'(t);
      e.tag = tag;
      q.push_back(e);
    end
  endtask

  // drives flags at tick 11 of the current cycle, decoys at tick 5 (R9)
  task automatic mcycle(input logic ed, input logic ex, input logic mv,
                        input logic ds, input int glitch, input string tag);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      rst = (k < glitch);
      if (k == 5) begin
        xdata_cyc = ~ed; xcode_exec = ~ex; mov_insn = ~mv; lat_off = ~ds;
      end
      if (k == 11) begin
        xdata_cyc = ed; xcode_exec = ex; mov_insn = mv; lat_off = ds;
      end
    end
    @(posedge clk);
    push_cycle(ed, ex, mv, ds, tag);
  endtask

  task automatic check_reset(input string tag);
    checks++;
    if (lat_stb !== 1'b0 || rd_stb_n !== 1'b1 || cyc_tick !== 4'd0) begin
      bad++;
      $display("FAIL %s reset state: got lat=%b rd_n=%b tick=%0d exp lat=0 rd_n=1 tick=0",
               tag, lat_stb, rd_stb_n, cyc_tick);
    end
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (lat_stb !== e.a || rd_stb_n !== e.p || cyc_tick !== e.t) begin
        bad++;
        $display("FAIL %s: got lat=%b rd_n=%b tick=%0d exp lat=%b rd_n=%b tick=%0d",
                 e.tag, lat_stb, rd_stb_n, cyc_tick, e.a, e.p, e.t);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (30) @(negedge clk);
    check_reset("R10 initial");
    repeat (3) @(negedge clk);
    check_reset("R10 held");
    rst = 1'b0;
    @(posedge clk);
    push_cycle(1'b0, 1'b0, 1'b0, 1'b0, "R10 first cycle R1");

    mcycle(0, 0, 0, 0, 0, "R2 normal R1");
    mcycle(1, 0, 0, 0, 0, "R3 data omission");
    mcycle(0, 0, 0, 1, 0, "R4 off held high");
    mcycle(0, 0, 1, 1, 0, "R5 off with move");
    mcycle(1, 0, 1, 1, 0, "R5 off move data R3");
    mcycle(0, 1, 0, 1, 0, "R6 off ignored R7");
    mcycle(0, 1, 0, 0, 0, "R7 fetch strobes");
    mcycle(1, 1, 0, 0, 0, "R8 data silences fetch");
    mcycle(1, 1, 0, 1, 0, "R8 R6 combined");
    mcycle(0, 0, 0, 0, 11, "R11 short reset ignored");
    mcycle(0, 1, 1, 0, 11, "R11 short reset R9");
    mcycle(0, 0, 0, 0, 0, "R9 decoy flags");

    repeat (12) @(negedge clk);
    rst = 1'b1;
    repeat (25) @(posedge clk);
    @(negedge clk);
    check_reset("R10 mid-run");
    rst = 1'b0;
    @(posedge clk);
    push_cycle(1'b0, 1'b0, 1'b0, 1'b0, "R10 flags cleared");
    mcycle(0, 1, 0, 0, 0, "R10 resume R7");
    repeat (13) @(negedge clk);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule